// File: doc/BRIEF.md
# Write-Only Two-Wire Target Receiver

This block is a synchronous target on a two-wire serial bus (I2C), and it accepts only write transfers. It samples the bus clock line and data line with the system clock, finds START and STOP conditions, and collects a 7-bit address followed by the direction bit. It acknowledges the transfer when the address equals either the configured device address or a fixed broadcast address. It then acknowledges exactly three data bytes and packs them into a 24-bit word. The word is handed on through a one-cycle strobe once the acknowledge clock of the last byte has fallen.

The block is meant to sit in front of a command decoder, such as the front end of a converter. It drives the data line only through an open-drain pull-down enable. A read request, an unknown address and any byte after the third are all refused by leaving the line released. A repeated START or a STOP in the middle of a transfer drops the partial word. The system clock must run at least 16 times faster than the bus clock.

The controller has seven states. IDLE waits for a START. ADDR shifts in the address byte. ADDR_ACK pulls the line low for the 9th clock. DATA shifts in a data byte. DATA_ACK acknowledges a data byte. DRAIN refuses all traffic after a complete word. IGNORE refuses a transfer that was not addressed to this target. The transitions are as follows. A START takes any state to ADDR, and a STOP takes any state to IDLE. ADDR goes to ADDR_ACK when the 8th clock falls on a matching write address, and to IGNORE otherwise. ADDR_ACK goes to DATA when the 9th clock falls. DATA goes to DATA_ACK when the 8th clock falls. DATA_ACK goes back to DATA while bytes remain, and goes to DRAIN with the strobe after the last byte.

Top module: `i2cw_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, the pull-down enable, the strobe and the busy flag are 0, and the word output is 0.
- R2: A START is a falling data line while the clock line is high, and a STOP is a rising data line while the clock line is high. A STOP before the third data byte is acknowledged ends the transfer without a strobe, clears busy and leaves the word output unchanged.
- R3: After a START, an address byte (bits 7..1 address, most significant first, bit 0 the direction) equal to `dev_addr` with direction 0 is acknowledged: the data line is held low during the high phase of the 9th clock.
- R4: The address 7'h73 (parameter GLOBAL_ADDR) is acknowledged as well, whatever `dev_addr` is.
- R5: An address that matches neither value is not acknowledged. No byte that follows it is acknowledged, busy stays 0 and no strobe is raised.
- R6: A matching address with direction 1 (read) is not acknowledged, and the data line stays released on that 9th clock.
- R7: Each of the first three data bytes is acknowledged. The word carries the first byte in bits 23..16, the second byte in bits 15..8 and the third byte in bits 7..0, each byte most significant bit first.
- R8: The strobe is high for exactly one cycle after the 9th clock of the third data byte falls, and the word output changes only together with the strobe.
- R9: Data bytes after the third are not acknowledged and raise no further strobe.
- R10: A repeated START in the middle of a word drops the partial word without a strobe. A new address and word that follow it are received normally.
- R11: Busy goes high together with the address acknowledge and stays high through the data bytes. It falls at the strobe or on an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| dev_addr | input | 7 | Configured target address |
| sda_pull_o | output | 1 | Open-drain pull-down enable for the data line |
| word_o | output | 24 | Last complete three-byte word |
| word_valid_o | output | 1 | One-cycle strobe when a word completes |
| busy_o | output | 1 | High while a word is being clocked in |

## Verification
The hardest situations to reach are the aborts: a repeated START or a STOP that falls between data bytes, after the target has already acknowledged some of the word. The bench builds these transfers from bit-level bus tasks that can issue START and STOP conditions at any byte boundary. A scoreboard holds only the words that should complete, so a strobe raised by a dropped word shows up as an unexpected result. An over-long transfer is used to reach the DRAIN state. There the refused 4th and 5th bytes are checked on the bus, and the scoreboard confirms that no second strobe appears.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_DRAIN,
        ST_IGNORE
    } rx_state_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-1:0], din};
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    // data edges while the clock line is high are bus conditions
    assign start_o = scl_lvl & sda_fall;
    assign stop_o  = scl_lvl & sda_rise;
endmodule

// File: rtl/i2cw_rx.sv
module i2cw_rx
    import i2cw_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter int              DATA_BYTES  = 3,
    parameter logic [ADDR_W-1:0] GLOBAL_ADDR = 7'h73
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    input  logic [ADDR_W-1:0]            dev_addr,
    output logic                         sda_pull_o,
    output logic [BYTE_W*DATA_BYTES-1:0] word_o,
    output logic                         word_valid_o,
    output logic                         busy_o
);
    localparam int WORD_W = BYTE_W * DATA_BYTES;
    localparam int BIT_W  = $clog2(BYTE_W + 1);
    localparam int CNT_W  = $clog2(DATA_BYTES) + 1;
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(DATA_BYTES - 1);

    // line 0 = clock, line 1 = data
    logic [1:0] line_in, line_lvl, line_rise, line_fall;
    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_in[g]),
            .lvl  (line_lvl[g]),
            .rise (line_rise[g]),
            .fall (line_fall[g])
        );
    end

    logic start_ev, stop_ev;
    i2cw_cond u_cond (
        .scl_lvl (line_lvl[0]),
        .sda_rise(line_rise[1]),
        .sda_fall(line_fall[1]),
        .start_o (start_ev),
        .stop_o  (stop_ev)
    );

    logic scl_rise, scl_fall, sda_lvl;
    assign scl_rise = line_rise[0];
    assign scl_fall = line_fall[0];
    assign sda_lvl  = line_lvl[1];

    rx_state_t           st, st_nx;
    logic [BIT_W-1:0]    bitcnt;
    logic [CNT_W-1:0]    bytecnt;
    logic [BYTE_W-1:0]   shreg;
    logic [WORD_W-1:0]   word_sh;
    logic                addr_hit;
    logic                byte_done;

    assign addr_hit  = ((shreg[BYTE_W-1:1] == dev_addr) ||
                        (shreg[BYTE_W-1:1] == GLOBAL_ADDR)) && !shreg[0];
    assign byte_done = scl_fall && (bitcnt == LAST_BIT);

    // next-state decision
    always_comb begin
        st_nx = st;
        if (start_ev) begin
            st_nx = ST_ADDR;
        end else if (stop_ev) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:     st_nx = ST_IDLE;
                ST_ADDR:     if (byte_done) st_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) st_nx = ST_DATA;
                ST_DATA:     if (byte_done) st_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) st_nx = (bytecnt == LAST_BYTE) ? ST_DRAIN : ST_DATA;
                ST_DRAIN:    st_nx = ST_DRAIN;
                ST_IGNORE:   st_nx = ST_IGNORE;
                default:     st_nx = ST_IDLE;
            endcase
        end
    end

    // state register and byte datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bitcnt  <= '0;
            bytecnt <= '0;
            shreg   <= '0;
            word_sh <= '0;
        end else begin
            st <= st_nx;

            if (start_ev || (st_nx != st)) begin
                bitcnt <= '0;
            end else if ((st == ST_ADDR || st == ST_DATA) && scl_rise && (bitcnt != LAST_BIT)) begin
                bitcnt <= bitcnt + 1'b1;
                shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
            end

            if (start_ev) begin
                bytecnt <= '0;
            end else if (st == ST_DATA_ACK && st_nx == ST_DATA) begin
                bytecnt <= bytecnt + 1'b1;
            end

            if (st == ST_DATA && st_nx == ST_DATA_ACK) begin
                word_sh <= {word_sh[WORD_W-BYTE_W-1:0], shreg};
            end
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_pull_o   <= 1'b0;
            busy_o       <= 1'b0;
            word_valid_o <= 1'b0;
            word_o       <= '0;
        end else begin
            sda_pull_o   <= (st_nx == ST_ADDR_ACK) || (st_nx == ST_DATA_ACK);
            busy_o       <= (st_nx == ST_ADDR_ACK) || (st_nx == ST_DATA) ||
                            (st_nx == ST_DATA_ACK);
            word_valid_o <= (st == ST_DATA_ACK) && (st_nx == ST_DRAIN);
            if ((st == ST_DATA_ACK) && (st_nx == ST_DRAIN)) begin
                word_o <= word_sh;
            end
        end
    end
endmodule

// File: rtl/i2cw_rx_chk.sv
module i2cw_rx_chk #(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_pull_o,
    input logic              busy_o,
    input logic              word_valid_o,
    input logic [WORD_W-1:0] word_o
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);                                    // R8

    AST_WORD_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> $stable(word_o));                                 // R8

    AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (!busy_o && $past(busy_o)));                       // R11

    AST_PULL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> busy_o);                                             // R11

    AST_BUSY_STARTS_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> sda_pull_o);                                      // R3

    AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !scl_i);                      // R3
endmodule

bind i2cw_rx i2cw_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_pull_o  (sda_pull_o),
    .busy_o      (busy_o),
    .word_valid_o(word_valid_o),
    .word_o      (word_o)
);

// File: tb/i2cw_rx_tb.sv
`timescale 1ns/1ps
module i2cw_rx_tb;
    localparam int Q = 8;   // quarter bus period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [6:0]  dev_addr = 7'h2A;
    logic        sda_bus;
    logic        sda_pull_o, word_valid_o, busy_o;
    logic [23:0] word_o;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_bus = sda_m & ~sda_pull_o;

    i2cw_rx u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .dev_addr(dev_addr), .sda_pull_o(sda_pull_o), .word_o(word_o),
        .word_valid_o(word_valid_o), .busy_o(busy_o)
    );

    int checks = 0;
    int fails  = 0;
    logic [23:0] exp_q[$];
    logic [23:0] last_word = 24'h0;
    logic        prev_valid = 1'b0;

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = ~sda_bus;
        wq(); scl_m = 1'b0; wq();
    endtask

    // full write: address then three bytes, each ack compared to exp_ack
    task automatic write_word(input string req, input logic [6:0] a,
                              input logic [23:0] w, input logic exp_ack);
        logic ack;
        if (exp_ack) begin
            exp_q.push_back(w);
            last_word = w;
        end
        bus_start();
        send_byte({a, 1'b0}, ack);
        check_eq(req, "address ack", ack, exp_ack);
        check_eq("R11", "busy during data", busy_o, exp_ack);
        for (int k = 2; k >= 0; k--) begin
            send_byte(w[k*8 +: 8], ack);
            check_eq(req, "data byte ack", ack, exp_ack);
        end
        check_eq("R11", "busy after word", busy_o, 1'b0);
        bus_stop();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid_o && prev_valid) begin
                checks++; fails++;
                $display("FAIL R8 strobe longer than one cycle actual=2 expected=1");
            end
            if (word_valid_o) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R8 unexpected strobe actual=%h expected=none", word_o);
                end else begin
                    check_eq("R7", "word content", word_o, exp_q.pop_front());
                end
            end
        end
        prev_valid = word_valid_o;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1", "pull in reset", sda_pull_o, 1'b0);
        check_eq("R1", "busy in reset", busy_o, 1'b0);
        check_eq("R1", "word in reset", word_o, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "valid after reset", word_valid_o, 1'b0);
        wq();

        // R3 R7 R8: own address
        write_word("R3", 7'h2A, 24'hA5C30F, 1'b1);
        check_eq("R8", "word after strobe", word_o, 24'hA5C30F);

        // R4: broadcast address
        write_word("R4", 7'h73, 24'h123456, 1'b1);

        // R5: foreign address
        write_word("R5", 7'h15, 24'hDEAD77, 1'b0);
        check_eq("R5", "word unchanged", word_o, last_word);

        // R6: read request to own address
        bus_start();
        send_byte({7'h2A, 1'b1}, ack);
        check_eq("R6", "read not acked", ack, 1'b0);
        check_eq("R6", "busy on read", busy_o, 1'b0);
        bus_stop();

        // R9: five data bytes, extra two refused
        exp_q.push_back(24'h0180FE); last_word = 24'h0180FE;
        bus_start();
        send_byte({7'h2A, 1'b0}, ack);
        check_eq("R9", "address ack", ack, 1'b1);
        send_byte(8'h01, ack); check_eq("R7", "byte1 ack", ack, 1'b1);
        send_byte(8'h80, ack); check_eq("R7", "byte2 ack", ack, 1'b1);
        send_byte(8'hFE, ack); check_eq("R7", "byte3 ack", ack, 1'b1);
        send_byte(8'h55, ack); check_eq("R9", "byte4 refused", ack, 1'b0);
        send_byte(8'h00, ack); check_eq("R9", "byte5 refused", ack, 1'b0);
        bus_stop();
        check_eq("R9", "word holds first three", word_o, 24'h0180FE);

        // R2: STOP after two bytes aborts
        bus_start();
        send_byte({7'h2A, 1'b0}, ack);
        check_eq("R2", "address ack", ack, 1'b1);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        check_eq("R11", "busy mid word", busy_o, 1'b1);
        bus_stop();
        check_eq("R2", "busy after stop", busy_o, 1'b0);
        check_eq("R2", "word unchanged after stop", word_o, last_word);

        // R10: repeated START after one byte, then a full word
        bus_start();
        send_byte({7'h73, 1'b0}, ack);
        send_byte(8'h99, ack);
        bus_start();
        check_eq("R10", "busy cleared by restart", busy_o, 1'b0);
        check_eq("R10", "word unchanged by restart", word_o, last_word);
        exp_q.push_back(24'h00FFAA); last_word = 24'h00FFAA;
        send_byte({7'h2A, 1'b0}, ack); check_eq("R10", "address ack after restart", ack, 1'b1);
        send_byte(8'h00, ack); check_eq("R10", "byte1 ack", ack, 1'b1);
        send_byte(8'hFF, ack); check_eq("R10", "byte2 ack", ack, 1'b1);
        send_byte(8'hAA, ack); check_eq("R10", "byte3 ack", ack, 1'b1);
        bus_stop();
        check_eq("R10", "word after restart", word_o, 24'h00FFAA);

        // R3: new configured address, all-ones word; old address refused
        dev_addr = 7'h7F;
        write_word("R5", 7'h2A, 24'h445566, 1'b0);
        write_word("R3", 7'h7F, 24'hFFFFFF, 1'b1);
        check_eq("R7", "all-ones word", word_o, 24'hFFFFFF);

        wq();
        check_eq("R8", "scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule